// File: doc/BRIEF.md
# Switch Forwarding Table Command Engine

This block holds the MAC forwarding table of a small Ethernet switch and lets a host maintain it through three 32-bit words. The words are a command word, a key word and an attribute word. The host writes the key and the attributes, then writes the command word with an opcode and the busy bit set. It then polls the busy bit until the engine drops it. Every operation is one linear pass over a fixed-depth register array, at one slot per clock. The pass is followed by one commit cycle.

The operations are:
- load an entry, or update it in place if its MAC is already present;
- remove an entry by MAC;
- three kinds of flush: all entries, only dynamic entries, or the entries of one port;
- exact lookup;
- ordered walk through the table, ended by an all-zero record.

Failed loads, removals and port flushes raise a sticky violation flag. The flag stays set until the host clears it.

Top module: `fdb_cmd_engine`

## Requirements
- R1: After reset all three words read zero and every table slot is empty (status 0).
- R2: Writing the command word with bit 3 (busy) set starts the opcode in bits [2:0]. Busy reads 1 for exactly DEPTH+1 cycles and then clears. Host writes to any word while busy is 1 are ignored.
- R3: The 48-bit MAC is carried with bytes 0..3 in the key word, byte 0 in bits [31:24]. Bytes 4 and 5 sit in command bits [31:16], byte 4 in [31:24] and byte 5 in [23:16]. Lookup and walk results come back in the same places.
- R4: Opcode 2 (load) writes the MAC and the attribute word into the lowest-index empty slot. If the MAC is already present, it overwrites that slot in place and uses no new slot.
- R5: A load of a new MAC into a table with no empty slot changes nothing in the table and sets the violation flag (command bit 12).
- R6: The violation flag stays at 1 through later successful operations. It returns to 0 only when the host writes the command word with bit 12 set.
- R7: Opcode 3 (purge) empties the slot holding the given MAC. If no slot holds it, the violation flag is set.
- R8: Opcode 1 empties every slot.
- R9: Attribute status bits [3:0] mark an entry: 15 is static, any other nonzero value (7 when written as dynamic) is dynamic, and 0 is empty. Opcode 4 empties only dynamic entries.
- R10: Opcode 5 empties the entries whose destination bitmap (attribute bits [16+NPORTS-1:16]) has the bit of the port in command bits [11:8]. Static entries survive unless command bit 4 is 1. If no entry is removed, the violation flag is set.
- R11: Opcode 7 (find) returns the stored attribute word of the matching entry. If no entry matches, it returns all-zero key, MAC and attribute words, and it does not touch the violation flag.
- R12: Opcode 6 (next) returns the lowest-index valid entry located after the slot that holds the supplied MAC. A zero MAC starts the walk at slot 0. When no such entry exists, it returns an all-zero MAC and attribute word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_sel | input | 2 | Word select: 0 command, 1 key, 2 attribute |
| host_wdata | input | 32 | Host write data |
| cmd_word | output | 32 | Command word readback (MAC bytes 4..5, violation, port, static-enable, busy, opcode) |
| key_word | output | 32 | Key word readback (MAC bytes 0..3) |
| attr_word | output | 32 | Attribute word readback |

## Verification
The bench fills the table completely, then loads one more new MAC. A design that picked a victim slot, or that forgot the flag, would lose an entry or stay silent. It rewrites an existing MAC while the table is full, which exposes any design that looks for a free slot before it checks for a hit. It also writes garbage while busy to catch an engine that accepts host writes in mid-scan. The walk is run over a table with a hole that was refilled by a later load. A wrong start point or a wrong "passed" rule would repeat or skip entries, or miss the zero terminator. The port flush is run twice, first keeping and then removing static entries. It is run once more on an empty table, where only a design that reports a miss would raise the flag.

// File: rtl/fdb_pkg.sv
// Shared opcodes and word-field positions for the forwarding table engine.
// Assumes the command word layout given in the block brief.
package fdb_pkg;

    typedef enum logic [2:0] {
        OP_NONE       = 3'd0,
        OP_FLUSH_ALL  = 3'd1,
        OP_LOAD       = 3'd2,
        OP_PURGE      = 3'd3,
        OP_FLUSH_DYN  = 3'd4,
        OP_FLUSH_PORT = 3'd5,
        OP_NEXT       = 3'd6,
        OP_FIND       = 3'd7
    } fdb_op_e;

    localparam int CMD_BUSY_BIT   = 3;
    localparam int CMD_STATIC_BIT = 4;
    localparam int CMD_PORT_LSB   = 8;
    localparam int CMD_VIOL_BIT   = 12;
    localparam int CMD_MAC_LSB    = 16;
    localparam int ATTR_PORT_LSB  = 16;
    localparam int MAC_W          = 48;
    localparam int ENT_W          = MAC_W + 32;
    localparam logic [3:0] ST_STATIC = 4'hF;
    localparam logic [3:0] ST_EMPTY  = 4'h0;

endpackage

// File: rtl/fdb_entry_store.sv
// Register array of table slots: one indexed read, one indexed write.
// Assumes a single writer per cycle; writing zero empties a slot.
module fdb_entry_store #(
    parameter int DEPTH = 16,
    parameter int ENT_W = 80,
    parameter int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [ENT_W-1:0] rd_ent,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [ENT_W-1:0] wr_ent
);

    logic [ENT_W-1:0] slot_q [DEPTH];

    // Slot storage: cleared on reset, written one slot at a time.
    always_ff @(posedge clk) begin
        for (int k = 0; k < DEPTH; k++) begin
            if (!rst_n) begin
                slot_q[k] <= '0;
            end else if (wr_en && wr_idx == IDX_W'(k)) begin
                slot_q[k] <= wr_ent;
            end
        end
    end

    // Combinational read of the slot under scan.
    assign rd_ent = slot_q[rd_idx];

    // R4
    wr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (32'(wr_idx) < DEPTH));

endmodule

// File: rtl/fdb_scan_seq.sv
// Operation sequencer: idle, one scan cycle per slot, one commit cycle.
// Assumes start is only raised while idle.
module fdb_scan_seq #(
    parameter int DEPTH = 16,
    parameter int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             busy,
    output logic             scan,
    output logic             fin,
    output logic [IDX_W-1:0] idx
);

    typedef enum logic [1:0] {S_IDLE, S_SCAN, S_FIN} seq_e;
    localparam int CNT_W = $clog2(DEPTH + 2) + 1;

    seq_e             state_q;
    logic [CNT_W-1:0] busy_cnt_q;

    // State and slot index progression.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            idx     <= '0;
        end else begin
            case (state_q)
                S_IDLE: if (start) begin
                    state_q <= S_SCAN;
                    idx     <= '0;
                end
                S_SCAN: if (idx == IDX_W'(DEPTH - 1)) begin
                    state_q <= S_FIN;
                end else begin
                    idx <= idx + 1'b1;
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign busy = (state_q != S_IDLE);
    assign scan = (state_q == S_SCAN);
    assign fin  = (state_q == S_FIN);

    // Length of the current busy window, for the bound check below.
    always_ff @(posedge clk) begin
        if (!rst_n)    busy_cnt_q <= '0;
        else if (busy) busy_cnt_q <= busy_cnt_q + 1'b1;
        else           busy_cnt_q <= '0;
    end

    // R2
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (32'(busy_cnt_q) <= DEPTH));

    // R2
    start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);

    // R2
    busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(fin));

endmodule

// File: rtl/fdb_slot_eval.sv
// Per-slot decision logic: validity, MAC match, and flush/purge removal.
// Assumes status 0 marks an empty slot and 15 a static one.
module fdb_slot_eval
    import fdb_pkg::*;
#(
    parameter int NPORTS = 7,
    parameter int PORT_W = 3
) (
    input  fdb_op_e           op,
    input  logic [MAC_W-1:0]  slot_mac,
    input  logic [3:0]        slot_status,
    input  logic [NPORTS-1:0] slot_ports,
    input  logic [MAC_W-1:0]  key_mac,
    input  logic [PORT_W-1:0] port_sel,
    input  logic              static_en,
    output logic              valid,
    output logic              mac_hit,
    output logic              kill
);

    logic [NPORTS-1:0] sel_mask;
    logic              port_hit;
    logic              is_static;

    // Decode slot properties and the removal decision for flush-type ops.
    always_comb begin
        valid     = (slot_status != ST_EMPTY);
        is_static = (slot_status == ST_STATIC);
        mac_hit   = valid && (slot_mac == key_mac);
        sel_mask  = NPORTS'(1) << port_sel;
        port_hit  = |(slot_ports & sel_mask);
        case (op)
            OP_FLUSH_ALL:  kill = valid;
            OP_FLUSH_DYN:  kill = valid && !is_static;
            OP_FLUSH_PORT: kill = valid && port_hit && (static_en || !is_static);
            OP_PURGE:      kill = mac_hit;
            default:       kill = 1'b0;
        endcase
    end

endmodule

// File: rtl/fdb_cmd_engine.sv
// Forwarding table command engine: host word registers, per-op scan
// bookkeeping, commit of loads and results, and the sticky violation flag.
// Assumes the host waits for busy to clear before the next command.
module fdb_cmd_engine
    import fdb_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int NPORTS = 7
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_we,
    input  logic [1:0]  host_sel,
    input  logic [31:0] host_wdata,
    output logic [31:0] cmd_word,
    output logic [31:0] key_word,
    output logic [31:0] attr_word
);

    localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int PORT_W = (NPORTS > 1) ? $clog2(NPORTS) : 1;

    logic [15:0]       mac_lo_q;
    logic [31:0]       key_q;
    logic [31:0]       attr_q;
    logic [PORT_W-1:0] port_q;
    logic              st_en_q;
    logic              viol_q;
    fdb_op_e           op_q;

    logic              hit_q, free_q, pass_q;
    logic [IDX_W-1:0]  hit_idx_q, free_idx_q;
    logic [ENT_W-1:0]  res_ent_q;

    logic              busy, scan, fin, start, host_ok;
    logic [IDX_W-1:0]  idx;
    logic [ENT_W-1:0]  slot_ent;
    logic [MAC_W-1:0]  key_mac;
    logic              s_valid, s_hit, s_kill;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [ENT_W-1:0]  wr_ent;

    assign key_mac = {key_q, mac_lo_q};
    assign host_ok = host_we && !busy;
    assign start   = host_ok && (host_sel == 2'd0) && host_wdata[CMD_BUSY_BIT];

    fdb_scan_seq #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .busy(busy), .scan(scan), .fin(fin), .idx(idx)
    );

    fdb_entry_store #(.DEPTH(DEPTH), .ENT_W(ENT_W), .IDX_W(IDX_W)) u_store (
        .clk(clk), .rst_n(rst_n), .rd_idx(idx), .rd_ent(slot_ent),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_ent(wr_ent)
    );

    fdb_slot_eval #(.NPORTS(NPORTS), .PORT_W(PORT_W)) u_eval (
        .op(op_q),
        .slot_mac(slot_ent[ENT_W-1:32]),
        .slot_status(slot_ent[3:0]),
        .slot_ports(slot_ent[ATTR_PORT_LSB +: NPORTS]),
        .key_mac(key_mac), .port_sel(port_q), .static_en(st_en_q),
        .valid(s_valid), .mac_hit(s_hit), .kill(s_kill)
    );

    // Table write port: removals during the scan, load commit at the end.
    always_comb begin
        wr_en  = (scan && s_kill) || (fin && op_q == OP_LOAD && (hit_q || free_q));
        wr_idx = fin ? (hit_q ? hit_idx_q : free_idx_q) : idx;
        wr_ent = fin ? {key_mac, attr_q} : '0;
    end

    // Host-visible words: host writes when idle, results and flag at commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mac_lo_q <= '0;
            key_q    <= '0;
            attr_q   <= '0;
            port_q   <= '0;
            st_en_q  <= 1'b0;
            viol_q   <= 1'b0;
            op_q     <= OP_NONE;
        end else begin
            if (host_ok) begin
                case (host_sel)
                    2'd0: begin
                        mac_lo_q <= host_wdata[CMD_MAC_LSB +: 16];
                        port_q   <= host_wdata[CMD_PORT_LSB +: PORT_W];
                        st_en_q  <= host_wdata[CMD_STATIC_BIT];
                        if (host_wdata[CMD_VIOL_BIT]) viol_q <= 1'b0;
                        if (host_wdata[CMD_BUSY_BIT]) op_q <= fdb_op_e'(host_wdata[2:0]);
                    end
                    2'd1:    key_q  <= host_wdata;
                    2'd2:    attr_q <= host_wdata;
                    default: ;
                endcase
            end
            if (fin) begin
                case (op_q)
                    OP_LOAD:  if (!hit_q && !free_q) viol_q <= 1'b1;
                    OP_PURGE, OP_FLUSH_PORT: if (!hit_q) viol_q <= 1'b1;
                    OP_FIND, OP_NEXT: {key_q, mac_lo_q, attr_q} <= hit_q ? res_ent_q : '0;
                    default: ;
                endcase
            end
        end
    end

    // Per-operation scan bookkeeping: hit, free slot, walk position, result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q      <= 1'b0;
            free_q     <= 1'b0;
            pass_q     <= 1'b0;
            hit_idx_q  <= '0;
            free_idx_q <= '0;
            res_ent_q  <= '0;
        end else if (start) begin
            hit_q  <= 1'b0;
            free_q <= 1'b0;
            pass_q <= ({key_q, host_wdata[CMD_MAC_LSB +: 16]} == '0);
        end else if (scan) begin
            case (op_q)
                OP_LOAD: begin
                    if (s_hit && !hit_q) begin
                        hit_q     <= 1'b1;
                        hit_idx_q <= idx;
                    end
                    if (!s_valid && !free_q) begin
                        free_q     <= 1'b1;
                        free_idx_q <= idx;
                    end
                end
                OP_PURGE, OP_FLUSH_PORT: if (s_kill) hit_q <= 1'b1;
                OP_FIND: if (s_hit && !hit_q) begin
                    hit_q     <= 1'b1;
                    res_ent_q <= slot_ent;
                end
                OP_NEXT: if (!hit_q) begin
                    if (pass_q && s_valid) begin
                        hit_q     <= 1'b1;
                        res_ent_q <= slot_ent;
                    end else if (s_hit) begin
                        pass_q <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign cmd_word  = {mac_lo_q, 3'b000, viol_q, 4'(port_q), 3'b000,
                        st_en_q, busy, op_q};
    assign key_word  = key_q;
    assign attr_word = attr_q;

    // R6
    viol_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(viol_q) |-> $past(fin));

    // R2
    busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !fin) |=> $stable(attr_q) && $stable(key_q));

    // R11
    find_miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fin && op_q == OP_FIND && !hit_q) |=> (attr_q == '0) && (key_q == '0));

    // R5
    full_load_viol_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fin && op_q == OP_LOAD && !hit_q && !free_q) |=> viol_q);

endmodule

// File: tb/tb_fdb_cmd_engine.sv
`timescale 1ns/1ps
module tb_fdb_cmd_engine;

    localparam int DEPTH = 16;
    localparam int NP    = 7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [1:0]  host_sel = 2'd0;
    logic [31:0] host_wdata = '0;
    logic [31:0] cmd_word, key_word, attr_word;

    fdb_cmd_engine #(.DEPTH(DEPTH), .NPORTS(NP)) dut (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
        .host_wdata(host_wdata), .cmd_word(cmd_word), .key_word(key_word),
        .attr_word(attr_word)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;

    logic [47:0] m_mac  [DEPTH];
    logic [31:0] m_attr [DEPTH];

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: act=%0d cycles exp<=150000", cycles);
            summary();
            $finish;
        end
    end

    task automatic chk(string req, string what, logic [47:0] act, logic [47:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: act=%h exp=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [47:0] mac_of(int i);
        return {8'h02, 8'(8'h10 + i), 8'h20, 8'h30, 8'(8'hA0 + i), 8'(8'h50 + i)};
    endfunction

    function automatic logic [31:0] attr_of(int i);
        logic [31:0] a;
        a = 32'(1 << (i % NP)) << 16;
        a |= 32'(i & 3) << 11;
        a |= 32'h400;
        a |= 32'((i >> 2) & 1) << 4;
        a |= (i % 2 == 1) ? 32'hF : 32'h7;
        return a;
    endfunction

    function automatic int m_find(logic [47:0] mac);
        for (int i = 0; i < DEPTH; i++)
            if (m_attr[i][3:0] != 0 && m_mac[i] == mac) return i;
        return -1;
    endfunction

    function automatic int m_next(logic [47:0] mac);
        bit pass = (mac == 48'h0);
        for (int i = 0; i < DEPTH; i++) begin
            if (pass && m_attr[i][3:0] != 0) return i;
            if (m_attr[i][3:0] != 0 && m_mac[i] == mac) pass = 1;
        end
        return -1;
    endfunction

    task automatic hwr(logic [1:0] sel, logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_sel = sel; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (cmd_word[3] && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic run_cmd(logic [2:0] op, logic [47:0] mac, int port, bit st, output int n);
        hwr(2'd1, mac[47:16]);
        hwr(2'd0, {mac[15:0], 3'b000, 1'b0, 4'(port), 3'b000, st, 1'b1, op});
        wait_idle(n);
    endtask

    task automatic clear_viol();
        hwr(2'd0, 32'h0000_1000);
    endtask

    task automatic check_all_finds(string req);
        int n;
        for (int i = 0; i < DEPTH; i++) begin
            int k;
            logic [47:0] mc;
            mc = mac_of(i);
            k = m_find(mc);
            run_cmd(3'd7, mc, 0, 0, n);
            chk(req, $sformatf("find attr of mac %0d", i), {16'h0, attr_word},
                {16'h0, (k < 0) ? 32'h0 : m_attr[k]});
        end
    endtask

    task automatic kill_model(int mode, int port, bit st);
        for (int i = 0; i < DEPTH; i++) begin
            bit v, s, ph, kl;
            v  = (m_attr[i][3:0] != 0);
            s  = (m_attr[i][3:0] == 4'hF);
            ph = m_attr[i][16 + port];
            kl = (mode == 1) ? v : (mode == 4) ? (v && !s) : (v && ph && (st || !s));
            if (kl) begin m_mac[i] = '0; m_attr[i] = '0; end
        end
    endtask

    initial begin
        int n;
        logic [31:0] na;
        for (int i = 0; i < DEPTH; i++) begin m_mac[i] = '0; m_attr[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "cmd_word", {16'h0, cmd_word}, 48'h0);
        chk("R1", "key_word", {16'h0, key_word}, 48'h0);
        chk("R1", "attr_word", {16'h0, attr_word}, 48'h0);
        run_cmd(3'd6, 48'h0, 0, 0, n);
        chk("R1", "empty walk status", {16'h0, attr_word}, 48'h0);

        // R4 fill the table, R2 busy length
        for (int i = 0; i < DEPTH; i++) begin
            hwr(2'd2, attr_of(i));
            run_cmd(3'd2, mac_of(i), 0, 0, n);
            m_mac[i] = mac_of(i); m_attr[i] = attr_of(i);
            if (i == 0) chk("R2", "busy cycles", 48'(n), 48'(DEPTH + 1));
        end
        chk("R4", "no violation while filling", {47'h0, cmd_word[12]}, 48'h0);

        // R4 overwrite in place on a full table; R2 write during busy ignored
        na = attr_of(3) | 32'h100;
        hwr(2'd2, na);
        hwr(2'd1, mac_of(3) >> 16);
        hwr(2'd0, {mac_of(3)[15:0], 3'b000, 1'b0, 4'h0, 3'b000, 1'b0, 1'b1, 3'd2});
        hwr(2'd2, 32'hDEAD_BEEF);
        wait_idle(n);
        chk("R2", "attr write ignored while busy", {16'h0, attr_word}, {16'h0, na});
        chk("R4", "in-place overwrite no violation", {47'h0, cmd_word[12]}, 48'h0);
        m_attr[3] = na;

        // R5 full table load
        hwr(2'd2, attr_of(17));
        run_cmd(3'd2, mac_of(17), 0, 0, n);
        chk("R5", "full load violation", {47'h0, cmd_word[12]}, 48'h1);
        // R6 sticky across a successful find
        run_cmd(3'd7, mac_of(0), 0, 0, n);
        chk("R6", "flag sticky", {47'h0, cmd_word[12]}, 48'h1);
        clear_viol();
        chk("R6", "flag cleared", {47'h0, cmd_word[12]}, 48'h0);
        run_cmd(3'd7, mac_of(17), 0, 0, n);
        chk("R5", "rejected mac absent", {16'h0, attr_word}, 48'h0);

        // R11 and R3 find every entry
        check_all_finds("R11");
        run_cmd(3'd7, mac_of(9), 0, 0, n);
        chk("R3", "bytes 0..3 in key word", {16'h0, key_word}, {16'h0, 8'h02, 8'h19, 8'h20, 8'h30});
        chk("R3", "bytes 4,5 in command", {32'h0, cmd_word[31:16]}, {32'h0, 8'hA9, 8'h59});
        run_cmd(3'd7, 48'h0A0B_0C0D_0E0F, 0, 0, n);
        chk("R11", "miss key", {16'h0, key_word}, 48'h0);
        chk("R11", "miss mac low", {32'h0, cmd_word[31:16]}, 48'h0);
        chk("R11", "miss attr", {16'h0, attr_word}, 48'h0);
        chk("R11", "miss no violation", {47'h0, cmd_word[12]}, 48'h0);

        // R7 purge
        run_cmd(3'd3, mac_of(5), 0, 0, n);
        chk("R7", "purge ok", {47'h0, cmd_word[12]}, 48'h0);
        m_mac[5] = '0; m_attr[5] = '0;
        run_cmd(3'd7, mac_of(5), 0, 0, n);
        chk("R7", "purged gone", {16'h0, attr_word}, 48'h0);
        run_cmd(3'd3, mac_of(5), 0, 0, n);
        chk("R7", "purge miss violation", {47'h0, cmd_word[12]}, 48'h1);
        clear_viol();

        // R4 refill lowest hole
        hwr(2'd2, attr_of(20));
        run_cmd(3'd2, mac_of(20), 0, 0, n);
        m_mac[5] = mac_of(20); m_attr[5] = attr_of(20);

        // R12 walk
        begin
            logic [47:0] cur;
            cur = '0;
            for (int step = 0; step < DEPTH + 2; step++) begin
                int k;
                logic [47:0] got;
                k = m_next(cur);
                run_cmd(3'd6, cur, 0, 0, n);
                got = {key_word, cmd_word[31:16]};
                chk("R12", $sformatf("walk mac step %0d", step), got, (k < 0) ? 48'h0 : m_mac[k]);
                chk("R12", $sformatf("walk attr step %0d", step), {16'h0, attr_word},
                    {16'h0, (k < 0) ? 32'h0 : m_attr[k]});
                if (k < 0) break;
                cur = got;
            end
        end

        // R10 port flush keeping static, then including static
        run_cmd(3'd5, 48'h0, 3, 0, n);
        kill_model(5, 3, 0);
        chk("R10", "port flush found entries", {47'h0, cmd_word[12]}, 48'h0);
        check_all_finds("R10");
        run_cmd(3'd5, 48'h0, 3, 1, n);
        kill_model(5, 3, 1);
        check_all_finds("R10");

        // R9 dynamic flush
        run_cmd(3'd4, 48'h0, 0, 0, n);
        kill_model(4, 0, 0);
        check_all_finds("R9");

        // R8 flush all
        run_cmd(3'd1, 48'h0, 0, 0, n);
        kill_model(1, 0, 0);
        run_cmd(3'd6, 48'h0, 0, 0, n);
        chk("R8", "walk after flush mac", {key_word, cmd_word[31:16]}, 48'h0);
        chk("R8", "walk after flush attr", {16'h0, attr_word}, 48'h0);
        check_all_finds("R8");

        // R10 port flush on empty table
        run_cmd(3'd5, 48'h0, 2, 1, n);
        chk("R10", "empty port flush violation", {47'h0, cmd_word[12]}, 48'h1);

        summary();
        $finish;
    end

endmodule